// File: doc/BRIEF.md
# Dual Segment Address Relocator

This block turns logical addresses into physical ones for a small processor that has no paging hardware. It keeps two independent segments, each described by a base (where the segment starts in physical memory) and a limit (how long it is). Instruction fetches are relocated through the program segment. Loads and stores are relocated through the data segment. Every access is also range-checked against the limit of its own segment. An access that falls outside its segment is reported as a fault, and the matching memory request is not issued.

For data accesses, the address arrives as a register operand plus a sign-extended immediate. The block does not add the operand and the immediate first and then add the base. Instead, it reduces the base, the operand and the immediate to two vectors in one carry-save layer and finishes with a single carry-propagate add. The range check is made on the logical address (operand plus immediate) and never on the relocated address.

Only supervisor code may load or read back the four segment registers, through a small configuration port. An attempt from user mode changes nothing and is flagged in the same cycle. All four registers clear on reset, so every access faults until supervisor software has set up the segments. Both address paths register their outputs, so a result appears one cycle after its request.

Top module: `dual_segment_relocator`

## Requirements
- R1: A fetch request with logical address L produces, one cycle later, physical address (L + program base) modulo 2^AW, resized to PW bits, with the fetch memory-valid output high when L is inside the segment.
- R2: A fetch faults when L is greater than or equal to the program limit, compared as unsigned AW-bit values.
- R3: A data request produces, one cycle later, physical address (data base + operand + sign-extended immediate) modulo 2^AW, resized to PW bits.
- R4: The data range check compares the logical address (operand + sign-extended immediate, modulo 2^AW) against the data limit, unsigned, whatever the base and whether or not the physical sum wraps.
- R5: A faulting access drives its memory-valid output low and its fault output high for that one cycle. A cycle with no request leaves both memory-valid and fault low one cycle later.
- R6: A configuration write with priv_super high loads cfg_wdata into the register selected by cfg_sel (0 program base, 1 program limit, 2 data base, 3 data limit). Accesses issued in the same cycle still use the old value, and accesses issued from the next cycle use the new one.
- R7: A configuration write with priv_super low leaves all four registers unchanged, and cfg_illegal is high in that same cycle.
- R8: A configuration read with priv_super high returns the selected register on cfg_rdata in the same cycle. A read with priv_super low returns zero and raises cfg_illegal.
- R9: Reset clears the four registers and all registered outputs, so after reset every fetch and data access faults until the limits are loaded.
- R10: dm_mem_we, one cycle after a data request, equals the request's dm_we when the access is issued, and is low otherwise.
- R11: Fetches use only the program pair and data accesses use only the data pair. Both paths may be active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_super | input | 1 | High while the processor is in supervisor mode |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_sel | input | 2 | Register select: 0 program base, 1 program limit, 2 data base, 3 data limit |
| cfg_wdata | input | AW | Configuration write value |
| cfg_rdata | output | AW | Configuration read value (zero unless a supervisor read) |
| cfg_illegal | output | 1 | Configuration access attempted from user mode |
| if_req | input | 1 | Fetch request |
| if_laddr | input | AW | Fetch logical address |
| if_mem_valid | output | 1 | Fetch memory request issued |
| if_paddr | output | PW | Fetch physical address |
| if_fault | output | 1 | Fetch out of program segment |
| dm_req | input | 1 | Data request |
| dm_we | input | 1 | Data request is a store |
| dm_rs | input | AW | Data address register operand |
| dm_imm | input | IW | Data address immediate, two's complement |
| dm_mem_valid | output | 1 | Data memory request issued |
| dm_mem_we | output | 1 | Issued data request is a store |
| dm_paddr | output | PW | Data physical address |
| dm_fault | output | 1 | Data access out of data segment |

## Verification
The segment registers can only be seen indirectly, so the bench checks them through the addresses and faults they produce. A corrupted base appears as a wrong physical address on the very next access through that segment. A corrupted limit appears as a fault that should not be there, or a missing one, once an address near the limit is presented. The bench therefore places addresses on both sides of each limit and reads the registers back through the supervisor port after each write. A write that leaked in from user mode, or a carry lost in the carry-save layer, shows up one cycle after the next request, and the reference model compares every cycle.

// File: rtl/seg_reloc_pkg.sv
package seg_reloc_pkg;

  // Segment register select codes; the encoding is visible on cfg_sel.
  typedef enum logic [1:0] {
    SEG_PROG_BASE  = 2'd0,
    SEG_PROG_LIMIT = 2'd1,
    SEG_DATA_BASE  = 2'd2,
    SEG_DATA_LIMIT = 2'd3
  } seg_reg_e;

  localparam int unsigned SEG_NUM_REGS = 4;

endpackage

// File: rtl/seg_reg_bank.sv
module seg_reg_bank
  import seg_reloc_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          priv_super,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] rdata,
  output logic          illegal,
  output logic          wr_accept,
  output logic [AW-1:0] prog_base,
  output logic [AW-1:0] prog_limit,
  output logic [AW-1:0] data_base,
  output logic [AW-1:0] data_limit
);

  logic [AW-1:0] regs [SEG_NUM_REGS];
  logic          rd_accept;

  // Accept strobes only in supervisor mode.
  assign wr_accept = wr_en & priv_super;
  assign rd_accept = rd_en & priv_super;
  assign illegal   = (wr_en | rd_en) & ~priv_super;

  for (genvar g = 0; g < SEG_NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (wr_accept && (sel == 2'(g))) begin
        regs[g] <= wdata;
      end
    end
  end

  assign rdata      = rd_accept ? regs[sel] : '0;
  assign prog_base  = regs[SEG_PROG_BASE];
  assign prog_limit = regs[SEG_PROG_LIMIT];
  assign data_base  = regs[SEG_DATA_BASE];
  assign data_limit = regs[SEG_DATA_LIMIT];

endmodule

// File: rtl/seg_fetch_xlate.sv
module seg_fetch_xlate #(
  parameter int unsigned AW = 32,
  parameter int unsigned PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] laddr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  output logic          viol_now,
  output logic          mem_valid,
  output logic [PW-1:0] paddr,
  output logic          fault
);

  function automatic logic [PW-1:0] relocate(input logic [AW-1:0] a,
                                             input logic [AW-1:0] b);
    logic [AW-1:0] s;
    s = a + b;
    return PW'(s);
  endfunction

  function automatic logic out_of_range(input logic [AW-1:0] a,
                                        input logic [AW-1:0] lim);
    return (a >= lim);
  endfunction

  logic [PW-1:0] paddr_now;

  assign viol_now  = out_of_range(laddr, limit);
  assign paddr_now = relocate(laddr, base);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      fault     <= 1'b0;
      paddr     <= '0;
    end else begin
      mem_valid <= req & ~viol_now;
      fault     <= req & viol_now;
      if (req) begin
        paddr <= paddr_now;
      end
    end
  end

endmodule

// File: rtl/seg_data_xlate.sv
module seg_data_xlate #(
  parameter int unsigned AW = 32,
  parameter int unsigned PW = 32,
  parameter int unsigned IW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] rs,
  input  logic [IW-1:0] imm,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  output logic [AW-1:0] laddr_now,
  output logic          viol_now,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [PW-1:0] paddr,
  output logic          fault
);

  localparam int unsigned EXT = AW - IW;

  function automatic logic [AW-1:0] sext_imm(input logic [IW-1:0] v);
    return {{EXT{v[IW-1]}}, v};
  endfunction

  // One carry-save layer folds three operands into sum and carry vectors.
  function automatic logic [2*AW-1:0] csa3(input logic [AW-1:0] a,
                                           input logic [AW-1:0] b,
                                           input logic [AW-1:0] c);
    logic [AW-1:0] s;
    logic [AW-1:0] cy;
    s  = a ^ b ^ c;
    cy = ((a & b) | (a & c) | (b & c)) << 1;
    return {cy, s};
  endfunction

  logic [AW-1:0]   imm_ext;
  logic [2*AW-1:0] csa_out;
  logic [AW-1:0]   csa_sum;
  logic [AW-1:0]   csa_carry;
  logic [AW-1:0]   phys_full;

  assign imm_ext   = sext_imm(imm);
  assign laddr_now = rs + imm_ext;
  assign viol_now  = (laddr_now >= limit);

  assign csa_out   = csa3(base, rs, imm_ext);
  assign csa_sum   = csa_out[AW-1:0];
  assign csa_carry = csa_out[2*AW-1:AW];
  assign phys_full = csa_sum + csa_carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_we    <= 1'b0;
      fault     <= 1'b0;
      paddr     <= '0;
    end else begin
      mem_valid <= req & ~viol_now;
      mem_we    <= req & ~viol_now & we;
      fault     <= req & viol_now;
      if (req) begin
        paddr <= PW'(phys_full);
      end
    end
  end

endmodule

// File: rtl/dual_segment_relocator.sv
module dual_segment_relocator #(
  parameter int unsigned AW = 32,
  parameter int unsigned PW = 32,
  parameter int unsigned IW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          priv_super,
  input  logic          cfg_wr_en,
  input  logic          cfg_rd_en,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  output logic          cfg_illegal,
  input  logic          if_req,
  input  logic [AW-1:0] if_laddr,
  output logic          if_mem_valid,
  output logic [PW-1:0] if_paddr,
  output logic          if_fault,
  input  logic          dm_req,
  input  logic          dm_we,
  input  logic [AW-1:0] dm_rs,
  input  logic [IW-1:0] dm_imm,
  output logic          dm_mem_valid,
  output logic          dm_mem_we,
  output logic [PW-1:0] dm_paddr,
  output logic          dm_fault
);

  logic [AW-1:0] prog_base;
  logic [AW-1:0] prog_limit;
  logic [AW-1:0] data_base;
  logic [AW-1:0] data_limit;
  logic          cfg_wr_accept;
  logic          if_viol_now;
  logic          dm_viol_now;
  logic [AW-1:0] dm_laddr_now;

  seg_reg_bank #(.AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .priv_super (priv_super),
    .wr_en      (cfg_wr_en),
    .rd_en      (cfg_rd_en),
    .sel        (cfg_sel),
    .wdata      (cfg_wdata),
    .rdata      (cfg_rdata),
    .illegal    (cfg_illegal),
    .wr_accept  (cfg_wr_accept),
    .prog_base  (prog_base),
    .prog_limit (prog_limit),
    .data_base  (data_base),
    .data_limit (data_limit)
  );

  seg_fetch_xlate #(.AW(AW), .PW(PW)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (if_req),
    .laddr     (if_laddr),
    .base      (prog_base),
    .limit     (prog_limit),
    .viol_now  (if_viol_now),
    .mem_valid (if_mem_valid),
    .paddr     (if_paddr),
    .fault     (if_fault)
  );

  seg_data_xlate #(.AW(AW), .PW(PW), .IW(IW)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (dm_req),
    .we        (dm_we),
    .rs        (dm_rs),
    .imm       (dm_imm),
    .base      (data_base),
    .limit     (data_limit),
    .laddr_now (dm_laddr_now),
    .viol_now  (dm_viol_now),
    .mem_valid (dm_mem_valid),
    .mem_we    (dm_mem_we),
    .paddr     (dm_paddr),
    .fault     (dm_fault)
  );

endmodule

// File: rtl/seg_reloc_chk.sv
module seg_reloc_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned PW = 32,
  parameter int unsigned IW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          priv_super,
  input logic          cfg_wr_en,
  input logic          cfg_illegal,
  input logic          if_req,
  input logic [AW-1:0] if_laddr,
  input logic          if_mem_valid,
  input logic          if_fault,
  input logic          dm_req,
  input logic [AW-1:0] dm_rs,
  input logic [IW-1:0] dm_imm,
  input logic          dm_mem_valid,
  input logic          dm_fault,
  input logic [PW-1:0] dm_paddr,
  input logic [AW-1:0] prog_limit,
  input logic [AW-1:0] data_base,
  input logic [AW-1:0] data_limit,
  input logic [AW-1:0] prog_base
);

  logic [AW-1:0] ref_dm_phys;
  assign ref_dm_phys = data_base + dm_rs + AW'($signed(dm_imm));

  // R7
  user_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && !priv_super) |=> $stable({prog_base, prog_limit, data_base, data_limit}));

  // R7
  illegal_only_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_illegal |-> !priv_super);

  // R5
  if_fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_fault |-> !if_mem_valid);

  // R5
  dm_fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dm_fault |-> !dm_mem_valid);

  // R5
  if_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !if_req |=> (!if_mem_valid && !if_fault));

  // R2
  if_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_req |=> (if_fault == ($past(if_laddr) >= $past(prog_limit))));

  // R3
  dm_phys_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dm_req |=> (dm_paddr == PW'($past(ref_dm_phys))));

endmodule

bind dual_segment_relocator seg_reloc_chk #(.AW(AW), .PW(PW), .IW(IW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .priv_super   (priv_super),
  .cfg_wr_en    (cfg_wr_en),
  .cfg_illegal  (cfg_illegal),
  .if_req       (if_req),
  .if_laddr     (if_laddr),
  .if_mem_valid (if_mem_valid),
  .if_fault     (if_fault),
  .dm_req       (dm_req),
  .dm_rs        (dm_rs),
  .dm_imm       (dm_imm),
  .dm_mem_valid (dm_mem_valid),
  .dm_fault     (dm_fault),
  .dm_paddr     (dm_paddr),
  .prog_limit   (prog_limit),
  .data_base    (data_base),
  .data_limit   (data_limit),
  .prog_base    (prog_base)
);

// File: tb/dual_segment_relocator_bench.sv
`timescale 1ns/1ps
module dual_segment_relocator_bench;

  localparam int AW = 32;
  localparam int PW = 32;
  localparam int IW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          priv_super = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic          cfg_rd_en = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [AW-1:0] cfg_rdata;
  logic          cfg_illegal;
  logic          if_req = 1'b0;
  logic [AW-1:0] if_laddr = '0;
  logic          if_mem_valid;
  logic [PW-1:0] if_paddr;
  logic          if_fault;
  logic          dm_req = 1'b0;
  logic          dm_we = 1'b0;
  logic [AW-1:0] dm_rs = '0;
  logic [IW-1:0] dm_imm = '0;
  logic          dm_mem_valid;
  logic          dm_mem_we;
  logic [PW-1:0] dm_paddr;
  logic          dm_fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state: the four segment registers, kept as plain integers.
  longint unsigned model [4];

  always #5 clk = ~clk;

  dual_segment_relocator #(.AW(AW), .PW(PW), .IW(IW)) u_dual_segment_relocator (.*);

  task automatic check(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Run one clock: check same-cycle outputs, advance, compare registered ones.
  task automatic cycle();
    longint unsigned mask;
    longint unsigned il, dl, exp_rd;
    bit ill, ifv, dmv;
    longint unsigned ifp, dmp;
    bit dwe, ireq, dreq;
    mask = (64'd1 << AW) - 1;
    #1;
    ill = (cfg_wr_en || cfg_rd_en) && !priv_super;
    exp_rd = (cfg_rd_en && priv_super) ? model[cfg_sel] : 0;
    check("R7", "cfg_illegal", cfg_illegal, ill);
    check("R8", "cfg_rdata", cfg_rdata, exp_rd);
    il   = if_laddr;
    ifv  = (il >= model[1]);
    ifp  = (il + model[0]) & mask;
    dl   = (longint'(dm_rs) + longint'($signed(dm_imm))) & mask;
    dmv  = (dl >= model[3]);
    dmp  = (dl + model[2]) & mask;
    dwe  = dm_we;
    ireq = if_req;
    dreq = dm_req;
    @(posedge clk);
    if (cfg_wr_en && priv_super) model[cfg_sel] = cfg_wdata;
    @(negedge clk);
    check("R5", "if_fault", if_fault, ireq && ifv);
    check("R1", "if_mem_valid", if_mem_valid, ireq && !ifv);
    if (ireq && !ifv) check("R1", "if_paddr", if_paddr, ifp);
    check("R5", "dm_fault", dm_fault, dreq && dmv);
    check("R4", "dm_mem_valid", dm_mem_valid, dreq && !dmv);
    check("R10", "dm_mem_we", dm_mem_we, dreq && !dmv && dwe);
    if (dreq && !dmv) check("R3", "dm_paddr", dm_paddr, dmp);
  endtask

  task automatic idle();
    cfg_wr_en = 0; cfg_rd_en = 0; if_req = 0; dm_req = 0; dm_we = 0;
  endtask

  task automatic wr(input bit sup, input logic [1:0] sel, input logic [AW-1:0] v);
    idle(); priv_super = sup; cfg_wr_en = 1; cfg_sel = sel; cfg_wdata = v;
    cycle(); idle();
  endtask

  task automatic rd(input bit sup, input logic [1:0] sel);
    idle(); priv_super = sup; cfg_rd_en = 1; cfg_sel = sel;
    cycle(); idle();
  endtask

  task automatic fetch(input logic [AW-1:0] a);
    idle(); if_req = 1; if_laddr = a; cycle(); idle();
  endtask

  task automatic dacc(input logic [AW-1:0] r, input logic [IW-1:0] i, input bit w);
    idle(); dm_req = 1; dm_rs = r; dm_imm = i; dm_we = w; cycle(); idle();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) model[k] = 0;
    repeat (3) @(negedge clk);
    // R9: registered outputs clear while in reset
    check("R9", "if_mem_valid in reset", if_mem_valid, 0);
    check("R9", "dm_mem_valid in reset", dm_mem_valid, 0);
    check("R9", "if_fault in reset", if_fault, 0);
    rst_n = 1;
    @(negedge clk);
    // R9: zero limits make every access fault
    fetch(32'h0);
    dacc(32'h0, 12'h0, 1'b1);
    // R8: supervisor readback of cleared registers
    for (int k = 0; k < 4; k++) rd(1, 2'(k));
    // R7: user write ignored; R8: user read gives zero and is flagged
    wr(0, 2'd1, 32'h0000_0400);
    fetch(32'h0);
    rd(0, 2'd1);
    // R6: supervisor setup
    wr(1, 2'd0, 32'h1000_0000);
    wr(1, 2'd1, 32'h0000_0400);
    wr(1, 2'd2, 32'h2000_0000);
    wr(1, 2'd3, 32'h0000_0800);
    for (int k = 0; k < 4; k++) rd(1, 2'(k));
    // R1 R2: around the program limit
    fetch(32'h0); fetch(32'h3FC); fetch(32'h400); fetch(32'hFFFF_FFFF);
    // R3 R4 R10: data accesses with signed immediates
    dacc(32'h100, 12'h010, 1'b1);
    dacc(32'h4, 12'hFFC, 1'b0);
    dacc(32'h7F0, 12'h010, 1'b1);
    dacc(32'h7F0, 12'h00F, 1'b1);
    dacc(32'h0, 12'hFFF, 1'b0);
    // R4: physical sum wraps but logical address is in range
    wr(1, 2'd2, 32'hFFFF_F000);
    wr(1, 2'd3, 32'h0000_2000);
    dacc(32'h1000, 12'h100, 1'b1);
    // R11: both paths in one cycle, each with its own pair
    idle(); if_req = 1; if_laddr = 32'h10; dm_req = 1; dm_rs = 32'h10; dm_imm = 12'h0;
    cycle(); idle();
    // R6: write and access in the same cycle use the old limit
    idle(); priv_super = 1; cfg_wr_en = 1; cfg_sel = 2'd1; cfg_wdata = 32'h0;
    if_req = 1; if_laddr = 32'h8; cycle(); idle();
    fetch(32'h8);
    // Mixed random traffic, compared every cycle
    for (int n = 0; n < 400; n++) begin
      priv_super = $urandom_range(0, 1);
      cfg_wr_en  = ($urandom_range(0, 5) == 0);
      cfg_rd_en  = $urandom_range(0, 1);
      cfg_sel    = 2'($urandom_range(0, 3));
      cfg_wdata  = ($urandom_range(0, 1) == 1) ? 32'($urandom_range(0, 4096)) : $urandom;
      if_req     = $urandom_range(0, 1);
      if_laddr   = 32'($urandom_range(0, 5000));
      dm_req     = $urandom_range(0, 1);
      dm_we      = $urandom_range(0, 1);
      dm_rs      = ($urandom_range(0, 3) == 0) ? $urandom : 32'($urandom_range(0, 5000));
      dm_imm     = 12'($urandom);
      cycle();
    end
    idle();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule